// File: doc/BRIEF.md
# Active-Clamp Inverter Gate Sequencer

This block produces the six gate commands of a single-stage isolated inverter: the main primary switch, the auxiliary clamp switch, and the four secondary switches that unfold the output onto the grid. A free-running carrier counter with a fixed period sets the switching cycle. The main switch conducts at the start of each cycle for a number of counts given by a duty word. After it turns off and a programmable dead time has passed, the active pair of secondary switches is turned on as a synchronous rectifier for freewheeling. The auxiliary clamp switch gets a short pre-pulse of programmable width. This pulse ends one dead time before the next main turn-on, instead of covering the whole off-time.

The grid-polarity input selects which secondary diagonal pair is held on for the whole half-cycle and which pair rectifies. The duty word, pre-pulse width, dead time and polarity are sampled only when the carrier wraps. When the polarity changes, one whole period runs with every secondary switch off before the new pairing takes effect.

A single finite-state machine sequences each period. Its states are:
- OFF: held in reset.
- MAIN: main switch on.
- CLAMP_DT: main off, leakage energy flowing into the clamp, dead time running.
- FREEWHEEL: rectifier pair on.
- AUX: clamp switch pre-pulse, rectifier still on.
- PRE_DT: dead time before the main switch turns on again.

The transitions are:
- OFF→MAIN or OFF→FREEWHEEL when reset is released, depending on the duty.
- MAIN→CLAMP_DT at duty end.
- CLAMP_DT→FREEWHEEL when the dead time expires.
- FREEWHEEL→AUX at the pre-pulse start.
- AUX→PRE_DT at the pre-pulse end.
- PRE_DT→MAIN at the carrier wrap.

Empty intervals are skipped.

Top module: `gate_sequencer`

## Requirements
- R1: A synchronous active-high reset drives all six gates low while it is held. The first carrier period after reset keeps all four secondary gates low.
- R2: The carrier period is PERIOD clocks, with count values 0 to PERIOD-1. The main gate is high exactly for the counts below the sampled duty D, so it rises only at count 0.
- R3: The duty is clamped to PERIOD − W − 2·T, where W is the pre-pulse width and T is the dead time. The value is 0 if W + 2·T ≥ PERIOD.
- R4: The synchronous-rectifier pair is high from count D+T through the end of the period. It is low at count 0, when the main switch turns on.
- R5: The auxiliary gate is high for counts PERIOD−T−W up to but not including PERIOD−T. With W = 0 it never rises. It is never high together with the main gate.
- R6: With pol_pos = 1, secondary switches 2 and 3 (g_sec[1], g_sec[2]) are held high, and switches 1 and 4 (g_sec[0], g_sec[3]) form the rectifier pair.
- R7: With pol_pos = 0, g_sec[0] and g_sec[3] are held high, and g_sec[1] and g_sec[2] form the rectifier pair.
- R8: duty, aux_width, dead_time and pol_pos are sampled only in the clock that starts count 0. Changes at any other time have no effect on the gates.
- R9: A period whose sampled polarity differs from the previous period's keeps all four secondary gates low for that whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty | input | CW | Requested main on-time in counts |
| aux_width | input | CW | Auxiliary pre-pulse width in counts |
| dead_time | input | CW | Dead time in counts |
| pol_pos | input | 1 | Grid polarity, 1 = positive half-cycle |
| g_main | output | 1 | Main primary switch gate |
| g_aux | output | 1 | Auxiliary clamp switch gate |
| g_sec | output | 4 | Secondary gates, bit i drives switch i+1 |

## Verification
The bench sweeps every duty word against every small combination of pre-pulse width and dead time. Duties above the limit check the clamp. If the clamp were wrong, the rectifier on-edge and the pre-pulse would collide or shift. Zero pre-pulse and zero dead time are included in the sweep. These catch an off-by-one interval boundary, which would move a gate edge by one count. Junk values are driven on all inputs away from the wrap, so a design that sampled them mid-period would produce wrong gate edges. The polarity toggles every few periods, which exposes a missing blanking period or swapped legs. A mid-run reset checks that every gate drops low and that the first period after reset is blanked.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;
    typedef enum logic [2:0] {
        GS_OFF,
        GS_MAIN,
        GS_CLAMP_DT,
        GS_FREEWHEEL,
        GS_AUX,
        GS_PRE_DT
    } gs_state_e;
endpackage

// File: rtl/gs_carrier.sv
`timescale 1ns/1ps
module gs_carrier #(
    parameter int PERIOD = 40,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign wrap    = (cnt_q == LAST);
    assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    assign cnt     = cnt_q;

    // reset parks on the last count so the first live clock opens a period
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LAST;
        else     cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/gs_cfg.sv
`timescale 1ns/1ps
module gs_cfg #(
    parameter int PERIOD = 40,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    input  logic [CW-1:0] duty_in,
    input  logic [CW-1:0] pre_in,
    input  logic [CW-1:0] dt_in,
    input  logic          pol_in,
    output logic [CW-1:0] nxt_duty,
    output logic [CW-1:0] nxt_pre,
    output logic [CW-1:0] nxt_dt,
    output logic          cur_pol,
    output logic          cur_blank
);
    localparam int XW = CW + 2;

    logic [XW-1:0] guard, dmax;
    logic [CW-1:0] duty_cl;
    logic [CW-1:0] duty_q, pre_q, dt_q;
    logic          pol_q, blank_q, first_q;

    // room the pre-pulse and both dead times need inside one period
    always_comb begin
        guard   = XW'(pre_in) + (XW'(dt_in) << 1);
        dmax    = (guard >= XW'(PERIOD)) ? '0 : XW'(PERIOD) - guard;
        duty_cl = (XW'(duty_in) > dmax) ? dmax[CW-1:0] : duty_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q  <= '0;
            pre_q   <= '0;
            dt_q    <= '0;
            pol_q   <= 1'b0;
            blank_q <= 1'b1;
            first_q <= 1'b1;
        end else if (wrap) begin
            duty_q  <= duty_cl;
            pre_q   <= pre_in;
            dt_q    <= dt_in;
            pol_q   <= pol_in;
            blank_q <= first_q | (pol_in != pol_q);
            first_q <= 1'b0;
        end
    end

    assign nxt_duty  = wrap ? duty_cl : duty_q;
    assign nxt_pre   = wrap ? pre_in  : pre_q;
    assign nxt_dt    = wrap ? dt_in   : dt_q;
    assign cur_pol   = pol_q;
    assign cur_blank = blank_q;
endmodule

// File: rtl/gs_sec_legs.sv
`timescale 1ns/1ps
module gs_sec_legs (
    input  logic       en,
    input  logic       sr_on,
    input  logic       pol_pos,
    output logic [3:0] sw
);
    for (genvar i = 0; i < 4; i++) begin : g_leg
        // switches 2 and 3 (index 1, 2) are the held pair on the positive half
        localparam logic HELD_POS = (i == 1 || i == 2);
        assign sw[i] = en & ((HELD_POS == pol_pos) ? 1'b1 : sr_on);
    end
endmodule

// File: rtl/gate_sequencer.sv
`timescale 1ns/1ps
module gate_sequencer
    import gs_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] aux_width,
    input  logic [CW-1:0] dead_time,
    input  logic          pol_pos,
    output logic          g_main,
    output logic          g_aux,
    output logic [3:0]    g_sec
);
    localparam int XW = CW + 2;

    logic [CW-1:0] cnt, cnt_nxt, nxt_duty, nxt_pre, nxt_dt;
    logic          wrap, cur_pol, cur_blank;
    logic          sr_on, active;
    gs_state_e     state_q, state_d;

    gs_carrier #(.PERIOD(PERIOD), .CW(CW)) u_carrier (
        .clk(clk), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
    );

    gs_cfg #(.PERIOD(PERIOD), .CW(CW)) u_cfg (
        .clk(clk), .rst(rst), .wrap(wrap),
        .duty_in(duty), .pre_in(aux_width), .dt_in(dead_time), .pol_in(pol_pos),
        .nxt_duty(nxt_duty), .nxt_pre(nxt_pre), .nxt_dt(nxt_dt),
        .cur_pol(cur_pol), .cur_blank(cur_blank)
    );

    // next state from the count the carrier is about to take
    always_comb begin
        logic [XW-1:0] c, d, t, w;
        c = XW'(cnt_nxt);
        d = XW'(nxt_duty);
        t = XW'(nxt_dt);
        w = XW'(nxt_pre);
        if (c < d)                            state_d = GS_MAIN;
        else if (c < d + t)                   state_d = GS_CLAMP_DT;
        else if (c < XW'(PERIOD) - t - w)     state_d = GS_FREEWHEEL;
        else if (c < XW'(PERIOD) - t)         state_d = GS_AUX;
        else                                  state_d = GS_PRE_DT;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GS_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        g_main = 1'b0;
        g_aux  = 1'b0;
        sr_on  = 1'b0;
        active = 1'b1;
        unique case (state_q)
            GS_OFF:       active = 1'b0;
            GS_MAIN:      g_main = 1'b1;
            GS_CLAMP_DT:  sr_on  = 1'b0;
            GS_FREEWHEEL: sr_on  = 1'b1;
            GS_AUX: begin
                g_aux = 1'b1;
                sr_on = 1'b1;
            end
            GS_PRE_DT:    sr_on  = 1'b1;
        endcase
    end

    gs_sec_legs u_legs (
        .en(active & ~cur_blank), .sr_on(sr_on), .pol_pos(cur_pol), .sw(g_sec)
    );

    // R1
    reset_off_chk: assert property (@(posedge clk)
        $past(rst) |-> (!g_main && !g_aux && g_sec == 4'b0000));

    // R5
    aux_main_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(g_main && g_aux));

    // R4
    sr_main_excl_chk: assert property (@(posedge clk) disable iff (rst)
        g_main |-> (g_sec != 4'b1111));

    // R2
    main_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g_main) |-> (cnt == '0));

    // R9
    blank_sec_chk: assert property (@(posedge clk) disable iff (rst)
        cur_blank |-> (g_sec == 4'b0000));
endmodule

// File: tb/gate_sequencer_tb.sv
`timescale 1ns/1ps
module gate_sequencer_tb;
    localparam int P  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] duty = '0, aux_width = '0, dead_time = '0;
    logic          pol_pos = 1'b0;
    logic          g_main, g_aux;
    logic [3:0]    g_sec;

    always #2 clk = ~clk;

    gate_sequencer #(.PERIOD(P), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .duty(duty), .aux_width(aux_width),
        .dead_time(dead_time), .pol_pos(pol_pos),
        .g_main(g_main), .g_aux(g_aux), .g_sec(g_sec)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    // bench model of the sampled period
    int mc = P - 1, md = 0, mp = 0, mt = 0;
    bit mpol = 0, mblank = 1, mfirst = 1, mpostrst = 1;

    function automatic logic [5:0] expv(int c);
        logic m, a, s;
        m = (c < md);
        a = (c >= P - mt - mp) && (c < P - mt);
        s = (c >= md + mt);
        if (mblank)    return {m, a, 4'b0000};
        else if (mpol) return {m, a, s, 1'b1, 1'b1, s};   // R6
        else           return {m, a, 1'b1, s, s, 1'b1};   // R7
    endfunction

    task automatic check(logic [5:0] exp, string tag);
        logic [5:0] act;
        act = {g_main, g_aux, g_sec[0], g_sec[1], g_sec[2], g_sec[3]};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s count=%0d got=%b exp=%b (main aux s1 s2 s3 s4)",
                     tag, mc, act, exp);
        end
    endtask

    task automatic tick(int d, int p, int t, bit pl);
        int nc, dmax;
        rst = 1'b0;
        nc = (mc == P - 1) ? 0 : mc + 1;
        if (nc == 0) begin
            duty = CW'(d); aux_width = CW'(p); dead_time = CW'(t); pol_pos = pl;
            dmax = (p + 2 * t >= P) ? 0 : P - p - 2 * t;     // R3
            md = (d > dmax) ? dmax : d;
            mp = p; mt = t;
            mpostrst = mfirst;
            mblank = mfirst || (pl != mpol);                 // R9, R1
            mpol = pl; mfirst = 0;
        end else begin
            // R8: junk away from the wrap must be ignored
            duty = CW'($urandom); aux_width = CW'($urandom);
            dead_time = CW'($urandom); pol_pos = 1'($urandom);
        end
        mc = nc;
        @(negedge clk);
        if (mpostrst)    check(expv(mc), "R1");
        else if (mblank) check(expv(mc), "R9");
        else             check(expv(mc), "R2 R3 R4 R5 R6 R7 R8");
    endtask

    initial begin
        int idx;
        repeat (3) begin
            @(negedge clk);
            check(6'b0, "R1");
        end
        idx = 0;
        for (int d = 0; d < 16; d++)
            for (int p = 0; p < 4; p++)
                for (int t = 0; t < 3; t++) begin
                    repeat (P) tick(d, p, t, 1'((idx / 3) % 2));
                    idx++;
                end
        // mid-period reset
        repeat (5) tick(6, 2, 1, 1'b1);
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(6'b0, "R1");
        end
        mc = P - 1; mfirst = 1; mpol = 0;
        repeat (3 * P) tick(15, 2, 1, 1'b0);
        repeat (2 * P) tick(5, 0, 0, 1'b1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule